// File: doc/BRIEF.md
# Modem control and edge detect

This block is the modem-control side of a serial port. It drives the two handshake outputs, DTR and RTS, from control register bits. It also samples the four modem status inputs, CTS, DCD, RI and DSR, through a two-stage synchronizer and exposes their current levels to a register read port.

CTS and DCD each have their own status detector. Each detector has an enable bit and a sense-select bit. When the sense-select bit is set, the detector latches a status bit on any change of the line, rising or falling. When it is clear, the detector latches the status bit whenever the line is high. Reading the status register clears the latched bits. The two latched bits combine into one interrupt cause, which has its own mask bit. A loopback flag is held in the control register and exported to the serializer.

Top module: `mdm_ctrl`

Register map: a write or read is taken on the rising clock edge where `wr_i` or `rd_i` is high. Read data is registered and appears on `rdata_o` after that edge.
- Address 0, control: bit 0 is the DTR control bit, bit 1 is the RTS control bit, bit 2 is the loopback enable.
- Address 1, status, write fields:
  - bit 0 enables the CTS detector;
  - bit 1 enables the DCD detector;
  - bit 2 selects any-edge sensing for CTS;
  - bit 3 selects any-edge sensing for DCD.
- Address 1, status, read fields:
  - bits 3:0 are the CTS, DCD, RI and DSR levels, in that order from bit 0;
  - bit 4 is the CTS latched status;
  - bit 5 is the DCD latched status;
  - bits 9:6 return the four write fields.
- Address 2, interrupt: bit 0 is the interrupt mask (read/write). Bit 1 is read-only and shows the pending cause, which is the OR of the two latched status bits.
- Address 3 reads as zero.

## Requirements
- R1: After reset, dtr_o and rts_o are 1, loop_o is 0, irq_o is 0, and every control and configuration bit is 0.
- R2: dtr_o is the inverse of control bit 0, and rts_o is the inverse of control bit 1. Both change after the clock edge that takes the write.
- R3: loop_o equals control bit 2.
- R4: Status read bits 3:0 return the CTS, DCD, RI and DSR levels as synchronized by two flip-flops. A pin change held for at least three cycles is visible in these bits.
- R5: With a detector enabled and any-edge sensing selected, both a rising and a falling change on its line set its latched bit. Changes on RI and DSR never set a latched bit.
- R6: With a detector disabled, no activity on its line sets its latched bit.
- R7: With a detector enabled and any-edge sensing clear, the latched bit is set in every cycle that the synchronized line is high, so it reads 1 again after a clearing read while the line stays high.
- R8: A read of the status register returns the latched bits as they were before the read and then clears them.
- R9: If a set condition for a latched bit occurs in the same cycle as the clearing read, the bit stays set after the read.
- R10: irq_o is high exactly when the interrupt mask bit is 1 and at least one latched bit is set. Interrupt read bit 1 shows the pending cause regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dcd_i | input | 1 | Carrier-detect pin, asynchronous |
| ri_i | input | 1 | Ring-indicator pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| dtr_o | output | 1 | Data-terminal-ready pin, inverted control bit |
| rts_o | output | 1 | Request-to-send pin, inverted control bit |
| loop_o | output | 1 | Loopback flag to the serializer |
| irq_o | output | 1 | Masked external-input interrupt |

## Verification
The assertions assume that `wr_i` and `rd_i` are never high in the same cycle. They also assume that the modem pins change only between clock edges.

The stimulus drives every strobe and pin on the falling edge. It issues reads and writes as separate one-cycle operations, and after each pin change it waits long enough for the synchronizer to settle.

The same-cycle collision in R9 needs exact timing. The bench changes CTS and times the read strobe so that it lands on the edge where the detector's set condition first appears. This relies on the default two-stage synchronizer.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_IRQ  = 2'd2;

  // status config field order, shared by write and readback
  typedef struct packed {
    logic dcd_ns;
    logic cts_ns;
    logic dcd_en;
    logic cts_en;
  } stat_cfg_t;

  typedef struct packed {
    logic loop_en;
    logic rts_ctl;
    logic dtr_ctl;
  } ctrl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic en_i,
  input  logic nosense_i,
  input  logic clr_i,
  output logic st_o
);
  logic prev_q, set, st_q;

  assign set = en_i & (nosense_i ? (lvl_i ^ prev_q) : lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      st_q   <= (st_q & ~clr_i) | set;
    end
  end

  assign st_o = st_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set) |=> st_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !st_o);
  p_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !st_o) |=> !st_o);
  p_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && nosense_i && (lvl_i != prev_q)) |=> st_o);
  p_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !nosense_i && lvl_i) |=> st_o);
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cts_i,
  input  logic              dcd_i,
  input  logic              ri_i,
  input  logic              dsr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              loop_o,
  output logic              irq_o
);
  localparam int unsigned N_LINES = 4;
  localparam int unsigned N_DET   = 2;
  localparam int unsigned CFG_W   = $bits(stat_cfg_t);
  localparam int unsigned CTRL_W  = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  stat_cfg_t         cfg_q;
  logic              mask_q;
  logic [N_LINES-1:0] lvl;
  logic [N_DET-1:0]   st, det_en, det_ns;
  logic               clr_rd;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  mdm_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dsr_i, ri_i, dcd_i, cts_i}),
    .q_o   (lvl)
  );

  assign det_en = {cfg_q.dcd_en, cfg_q.cts_en};
  assign det_ns = {cfg_q.dcd_ns, cfg_q.cts_ns};
  assign clr_rd = rd_i & (addr_i == A_STAT);

  // only CTS (line 0) and DCD (line 1) carry detectors
  for (genvar i = 0; i < N_DET; i++) begin : g_det
    mdm_edge u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_i    (lvl[i]),
      .en_i     (det_en[i]),
      .nosense_i(det_ns[i]),
      .clr_i    (clr_rd),
      .st_o     (st[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      mask_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CTRL:  ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        A_STAT:  cfg_q  <= stat_cfg_t'(wdata_i[CFG_W-1:0]);
        A_IRQ:   mask_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_CTRL: rd_mux[CTRL_W-1:0] = ctrl_q;
      A_STAT: begin
        rd_mux[N_LINES-1:0]                          = lvl;
        rd_mux[N_LINES +: N_DET]                     = st;
        rd_mux[N_LINES+N_DET +: CFG_W]               = cfg_q;
      end
      A_IRQ: rd_mux[1:0] = {|st, mask_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign dtr_o   = ~ctrl_q.dtr_ctl;
  assign rts_o   = ~ctrl_q.rts_ctl;
  assign loop_o  = ctrl_q.loop_en;
  assign irq_o   = mask_q & (|st);

  p_no_irq_unmasked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_IRQ && !wdata_i[0]) |=> !irq_o);
  p_dtr_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTRL) |=> (dtr_o != $past(wdata_i[0])));
  p_loop_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTRL) |=> (loop_o == $past(wdata_i[2])));
  p_pins_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_CTRL) |=> ($stable(dtr_o) && $stable(rts_o)));
endmodule

// File: tb/sim_mdm_ctrl.sv
module sim_mdm_ctrl;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cts = 0, dcd = 0, ri = 0, dsr = 0;
  logic wr = 0, rd = 0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic dtr, rts, loopf, irq;
  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  mdm_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cts_i(cts), .dcd_i(dcd), .ri_i(ri), .dsr_i(dsr),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dtr_o(dtr), .rts_o(rts), .loop_o(loopf), .irq_o(irq)
  );

  // {ctl[2:0], pins{dsr,ri,dcd,cts}, exp{loop,rts,dtr}}
  localparam logic [9:0] VECS [6] = '{
    10'b000_0000_011, 10'b001_0001_010, 10'b010_0110_001,
    10'b111_1111_100, 10'b100_1010_111, 10'b011_0101_000
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R1 pins after reset", {28'd0, irq, loopf, rts, dtr}, 32'b0011);
    rst_n = 1;
    rd_reg(2'd0, d); chk("R1 ctrl reset", d, 0);
    rd_reg(2'd1, d); chk("R1 status reset", d, 0);

    // table walk: R2, R3, R4, R6 (detectors disabled)
    foreach (VECS[i]) begin
      wr_reg(2'd0, {13'd0, VECS[i][9:7]});
      {dsr, ri, dcd, cts} = VECS[i][6:3];
      settle();
      chk("R2 R3 pins", {29'd0, loopf, rts, dtr}, {29'd0, VECS[i][2:0]});
      rd_reg(2'd1, d);
      chk("R4 levels", d[3:0], VECS[i][6:3]);
      chk("R6 no status when disabled", d[5:4], 0);
    end
    {dsr, ri, dcd, cts} = 4'b0000;
    settle();

    // any-edge mode, both lines
    wr_reg(2'd1, 16'b1111);
    rd_reg(2'd1, d); chk("R8 cfg readback", d[9:6], 4'b1111);
    rd_reg(2'd1, d);
    cts = 1; settle();
    rd_reg(2'd1, d); chk("R5 cts rise", d[5:4], 2'b01);
    rd_reg(2'd1, d); chk("R8 cleared by read", d[5:4], 2'b00);
    cts = 0; settle();
    rd_reg(2'd1, d); chk("R5 cts fall", d[5:4], 2'b01);
    ri = 1; dsr = 1; settle();
    rd_reg(2'd1, d); chk("R5 ri dsr ignored", d[5:4], 2'b00);
    ri = 0; dsr = 0;
    dcd = 1; settle();
    chk("R10 masked irq", irq, 0);
    rd_reg(2'd2, d); chk("R10 pending visible", d[1:0], 2'b10);
    wr_reg(2'd2, 16'd1);
    chk("R10 irq raised", irq, 1);
    rd_reg(2'd1, d); chk("R5 dcd rise", d[5:4], 2'b10);
    chk("R10 irq drops after clear", irq, 0);
    dcd = 0; settle();
    rd_reg(2'd1, d);

    // same-cycle set and clear
    rd_reg(2'd1, d);
    @(negedge clk); cts = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd = 1; addr = 2'd1;
    @(negedge clk); rd = 0; d = rdata;
    chk("R9 read returns pre-state", d[4], 0);
    rd_reg(2'd1, d); chk("R9 status kept", d[4], 1);
    cts = 0; settle();
    rd_reg(2'd1, d);

    // disabled detectors
    wr_reg(2'd1, 16'b1100);
    cts = 1; dcd = 1; settle(); cts = 0; dcd = 0; settle();
    rd_reg(2'd1, d); chk("R6 disabled toggles", d[5:4], 0);
    chk("R6 no irq", irq, 0);

    // level mode on CTS
    wr_reg(2'd1, 16'b0001);
    cts = 1; settle();
    rd_reg(2'd1, d); chk("R7 level set", d[4], 1);
    rd_reg(2'd1, d); chk("R7 level re-sets", d[4], 1);
    cts = 0; settle();
    rd_reg(2'd1, d);
    rd_reg(2'd1, d); chk("R7 cleared when low", d[4], 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule